// File: doc/BRIEF.md
# Single-Slot Task Request Mailbox

This block is a one-word mailbox between a requester and a background worker. The requester submits a starting address. The submit is accepted or refused in the same cycle. It is accepted when no request is pending, and refused when one is. On acceptance, the stored word becomes the address with its top bit set as a pending marker. The submitter gets that word back as a nonzero result, and the worker receives a one-cycle wake pulse. On refusal, the result is zero and nothing changes.

The worker fetches by raising a fetch request. If the marker is set, the block signals a dispatch and presents the stored address in that cycle, and the slot returns to zero on the next clock edge. If the slot is empty, the fetch has no effect, and the idle output tells the worker to wait for the next wake pulse.

When a fetch and a submit arrive in the same cycle, the fetch is applied first. The submit therefore always finds a free slot in that cycle.

Top module: `task_mailbox`

## Requirements
- R1: While reset is asserted and right after it, the slot is empty: idle is 1, wake is 0 and fetch_go is 0.
- R2: A submit to an empty slot (bit 15 clear) is accepted. sub_result equals 0x8000 OR the 15-bit address in that cycle, and from the next cycle the slot holds that word.
- R3: A submit while bit 15 of the slot is set, with no fetch in the same cycle, is refused. sub_result is 0 and the slot keeps its previous contents.
- R4: wake is high for exactly the one cycle that follows each accepted submit, and is low after any cycle with no accepted submit.
- R5: A fetch while a request is pending raises fetch_go in that cycle with fetch_addr equal to the stored address, and the slot is zero from the next cycle unless a submit is accepted in the same cycle.
- R6: A fetch on an empty slot keeps fetch_go low and leaves the slot empty.
- R7: A submit and a fetch in the same cycle on a pending slot both take effect. The fetch returns the old address, the submit is accepted, and the slot then holds the new word.
- R8: idle equals the inverse of bit 15 of the slot, and sub_result is 0 in any cycle without a submit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_valid | input | 1 | Submit attempt this cycle |
| sub_addr | input | 15 | Requested start address |
| sub_result | output | 16 | Stored word if accepted, zero if refused |
| wake | output | 1 | One-cycle worker wake pulse |
| fetch_req | input | 1 | Worker fetch of the slot |
| fetch_go | output | 1 | Fetch found a pending request: dispatch |
| fetch_addr | output | 15 | Stored start address |
| idle | output | 1 | No request pending; worker should wait |

## Verification
The hardest situation to reach is a submit and a fetch in the same cycle while a request is pending. This is the only case where a pending slot accepts a new word. It also includes back-to-back accepted submits, where the wake output stays high over several cycles. Random stimulus with high submit and fetch rates reaches these cases often. Directed sequences also force them: fill the slot, then fetch and submit together, several times in a row, with a refused submit placed between them.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_ADDR_W = 15;

  // Submit may proceed when the slot, seen after any fetch this cycle, is free.
  function automatic logic mbx_slot_free(input logic pend_flag, input logic fetching);
    return fetching || !pend_flag;
  endfunction
endpackage

// File: rtl/mbx_slot_reg.sv
module mbx_slot_reg #(
  parameter int unsigned ADDR_W = mbx_pkg::MBX_ADDR_W,
  localparam int unsigned WORD_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_valid,
  input  logic [ADDR_W-1:0] sub_addr,
  input  logic              fetch_req,
  output logic [WORD_W-1:0] slot_q,
  output logic              accept,
  output logic [WORD_W-1:0] packed_word
);
  logic [WORD_W-1:0] base_word;
  logic [WORD_W-1:0] slot_d;

  function automatic logic [WORD_W-1:0] pack_req(input logic [ADDR_W-1:0] a);
    return {1'b1, a};
  endfunction

  always_comb begin
    base_word   = fetch_req ? '0 : slot_q;
    accept      = sub_valid && mbx_pkg::mbx_slot_free(slot_q[WORD_W-1], fetch_req);
    packed_word = pack_req(sub_addr);
    slot_d      = accept ? packed_word : base_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end
endmodule

// File: rtl/mbx_wake_pulse.sv
module mbx_wake_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire;
  end
endmodule

// File: rtl/task_mailbox.sv
module task_mailbox #(
  parameter int unsigned ADDR_W = mbx_pkg::MBX_ADDR_W,
  localparam int unsigned WORD_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_valid,
  input  logic [ADDR_W-1:0] sub_addr,
  output logic [WORD_W-1:0] sub_result,
  output logic              wake,
  input  logic              fetch_req,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              idle
);
  logic [WORD_W-1:0] slot_q;
  logic              sub_accept;
  logic [WORD_W-1:0] sub_word;
  logic              slot_pend;

  mbx_slot_reg #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_addr(sub_addr),
    .fetch_req(fetch_req), .slot_q(slot_q), .accept(sub_accept),
    .packed_word(sub_word)
  );

  mbx_wake_pulse u_wake (
    .clk(clk), .rst_n(rst_n), .fire(sub_accept), .pulse(wake)
  );

  assign slot_pend  = slot_q[WORD_W-1];
  assign sub_result = sub_accept ? sub_word : '0;
  assign fetch_go   = fetch_req && slot_pend;
  assign fetch_addr = slot_q[ADDR_W-1:0];
  assign idle       = !slot_pend;
endmodule

// File: rtl/task_mailbox_chk.sv
module task_mailbox_chk #(
  parameter int unsigned ADDR_W = 15,
  localparam int unsigned WORD_W = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sub_valid,
  input logic              fetch_req,
  input logic [WORD_W-1:0] sub_result,
  input logic [WORD_W-1:0] slot_q,
  input logic              sub_accept,
  input logic              wake,
  input logic              fetch_go,
  input logic              idle
);
  // R2
  accepted_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_accept |-> sub_result[WORD_W-1]);
  // R3
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !fetch_req && slot_q[WORD_W-1]) |-> (sub_result == '0));
  // R3
  refused_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !fetch_req && slot_q[WORD_W-1]) |=> $stable(slot_q));
  // R4
  wake_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_accept |=> wake);
  // R4
  wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_accept |=> !wake);
  // R5
  fetch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !sub_valid) |=> idle);
  // R8
  no_submit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_valid |-> (sub_result == '0));
endmodule

bind task_mailbox task_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .fetch_req(fetch_req),
  .sub_result(sub_result), .slot_q(slot_q), .sub_accept(sub_accept),
  .wake(wake), .fetch_go(fetch_go), .idle(idle)
);

// File: tb/test_task_mailbox.sv
`timescale 1ns/1ps
module test_task_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_valid = 1'b0;
  logic [14:0] sub_addr = '0;
  logic [15:0] sub_result;
  logic        wake;
  logic        fetch_req = 1'b0;
  logic        fetch_go;
  logic [14:0] fetch_addr;
  logic        idle;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] m_slot = '0;
  logic        m_wake = 1'b0;

  always #4 clk = ~clk;

  task_mailbox i_task_mailbox (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_addr(sub_addr),
    .sub_result(sub_result), .wake(wake), .fetch_req(fetch_req),
    .fetch_go(fetch_go), .fetch_addr(fetch_addr), .idle(idle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_result(input logic [15:0] s, input logic sv,
                                             input logic fe, input logic [14:0] a);
    logic [15:0] after_fetch;
    after_fetch = fe ? 16'h0 : s;
    if (sv && after_fetch[15] == 1'b0) return 16'h8000 | {1'b0, a};
    return 16'h0;
  endfunction

  task automatic step(input logic sv, input logic fe, input logic [14:0] a);
    logic [15:0] r;
    string tag;
    @(negedge clk);
    sub_valid = sv; fetch_req = fe; sub_addr = a;
    #1;
    r = exp_result(m_slot, sv, fe, a);
    if (!sv) tag = "R8";
    else if (fe && m_slot[15]) tag = "R7";
    else if (m_slot[15]) tag = "R3";
    else tag = "R2";
    chk(tag, sub_result, r);
    chk(fe ? (m_slot[15] ? "R5" : "R6") : "R5", fetch_go, fe && m_slot[15]);
    if (fe && m_slot[15]) chk("R5", fetch_addr, m_slot[14:0]);
    chk("R8", idle, !m_slot[15]);
    chk("R4", wake, m_wake);
    m_wake = (r != 16'h0);
    if (r != 16'h0) m_slot = r;
    else if (fe) m_slot = 16'h0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R1", idle, 1'b1);
    chk("R1", wake, 1'b0);
    chk("R1", fetch_go, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 15'h0);              // R1 after reset
    step(1'b0, 1'b1, 15'h0);              // R6 fetch on empty
    step(1'b0, 1'b0, 15'h0);
    step(1'b1, 1'b0, 15'h0000);           // R2 address zero still nonzero
    step(1'b1, 1'b0, 15'h1234);           // R3 refused
    step(1'b0, 1'b0, 15'h0);              // R4 single pulse
    step(1'b0, 1'b1, 15'h0);              // R5 fetch
    step(1'b1, 1'b0, 15'h7FFF);           // R2 all ones
    step(1'b1, 1'b1, 15'h0ABC);           // R7
    step(1'b1, 1'b1, 15'h0555);           // R7 again, back-to-back wake
    step(1'b1, 1'b0, 15'h2222);           // R3
    step(1'b0, 1'b1, 15'h0);              // R5
    step(1'b0, 1'b1, 15'h0);              // R6
    step(1'b0, 1'b0, 15'h0);
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 3) != 0, ($urandom % 4) == 0, 15'($urandom));
    end
    step(1'b0, 1'b0, 15'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule